// File: doc/BRIEF.md
# Paired byte FIFOs with level-triggered interrupts

This block is the data buffering and interrupt front end of a serial transfer engine. It holds two byte queues. The outbound queue is filled by software through a register port and drained by the shift logic. The inbound queue is filled by the shift logic and drained by software. Each queue has a programmable threshold. The block compares the occupancy of each queue against its threshold every cycle and turns the result into interrupt status. Software can therefore refill the outbound queue or empty the inbound queue in bursts instead of byte by byte.

Status bits are sticky, and software clears them by writing ones. A per-bit enable mask selects which bits drive the single interrupt line. Each queue also has its own flush control, which clears itself. Software writes the flush bit and polls until it reads back as zero. The shift logic connects through simple push and pop strobes, plus two event pulses: transfer finished and chip select released.

The register port takes a 3-bit word index. Index 0 is control, 1 is levels, 2 is the interrupt enable, 3 is the interrupt status, 4 is the outbound data write and 5 is the inbound data read. Read data is combinational from the index.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After reset, both queues are empty. Control reads 0x00000001, which is an outbound threshold of 0 and an inbound threshold of 1. The enable mask reads 0 and `irq_o` is low. Once the first post-reset cycle has passed, status reads 0x32, made up of inbound empty, outbound request and outbound empty.
- R2: A write to index 4 appends `reg_wdata[7:0]` to the outbound queue. `tx_data_o` always shows the oldest entry, and `tx_pop_i` removes that entry. The outbound count is read at index 1, bits 23:16.
- R3: `rx_push_i` appends `rx_data_i` to the inbound queue. A read of index 5 returns the oldest entry and removes it. The inbound count is read at index 1, bits 7:0.
- R4: Status bit 4 (outbound request) is set while the outbound count is at or below control bits 23:16. Status bit 0 (inbound ready) is set while the inbound count is at or above control bits 7:0. Each level condition reaches status one cycle after the count changes.
- R5: Status bit 1 marks inbound empty, bit 2 inbound full, bit 5 outbound empty and bit 6 outbound full. A queue is full at 64 entries, and the count never exceeds 64.
- R6: A write to index 4 while the outbound queue is full drops the byte and sets status bit 10. A pop while the outbound queue is empty sets status bit 11, and `tx_data_o` reads 0 while the queue is empty.
- R7: A push while the inbound queue is full drops the byte and sets status bit 8. A read of index 5 while the inbound queue is empty returns 0 and sets status bit 9.
- R8: Writing index 3 clears each status bit written as 1 and leaves bits written as 0 unchanged. A level bit whose condition still holds is set again in the same cycle.
- R9: Writing control with bit 31 flushes the outbound queue, and writing it with bit 15 flushes the inbound queue. The bit reads back as 1 for one cycle and then as 0, and the queue is empty from that point on.
- R10: `irq_o` is high exactly when some status bit is set whose bit in the enable mask at index 2 is also set.
- R11: A pulse on `xfer_done_i` sets status bit 12, and a pulse on `cs_release_i` sets status bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the inbound queue at index 5) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from index |
| tx_pop_i | input | 1 | Shift logic takes the oldest outbound byte |
| tx_data_o | output | 8 | Oldest outbound byte, 0 when the queue is empty |
| rx_push_i | input | 1 | Shift logic delivers an inbound byte |
| rx_data_i | input | 8 | Inbound byte |
| xfer_done_i | input | 1 | Transfer finished pulse |
| cs_release_i | input | 1 | Chip select released pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted pointer or count would appear in the level register on the next read. It would also show up as bytes coming out in the wrong order or as zeros at the data outputs, within the same pass that drains the queue. A wrong comparison or a stuck status flop would change the value read from index 3 one cycle after the triggering count change. The stimulus deliberately steps the counts across each threshold so that this cycle is observed. A flush that fails to clear itself would be seen directly, because the control bit would still read back as 1 two cycles after it was written.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

  localparam int NB_IRQ = 14;

  typedef enum logic [2:0] {
    A_CTL = 3'd0,
    A_LVL = 3'd1,
    A_IEN = 3'd2,
    A_STS = 3'd3,
    A_TXD = 3'd4,
    A_RXD = 3'd5
  } reg_idx_e;

  // status bit positions (software decodes these)
  localparam int B_RX_RDY  = 0;
  localparam int B_RX_EMP  = 1;
  localparam int B_RX_FULL = 2;
  localparam int B_TX_REQ  = 4;
  localparam int B_TX_EMP  = 5;
  localparam int B_TX_FULL = 6;
  localparam int B_RX_OVR  = 8;
  localparam int B_RX_UDR  = 9;
  localparam int B_TX_OVR  = 10;
  localparam int B_TX_UDR  = 11;
  localparam int B_DONE    = 12;
  localparam int B_CSREL   = 13;

  // control field positions
  localparam int C_TX_FLUSH = 31;
  localparam int C_TX_TRIG  = 16;
  localparam int C_RX_FLUSH = 15;
  localparam int C_RX_TRIG  = 0;

endpackage

// File: rtl/xfp_fifo.sv
module xfp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         ovf,
  output logic                         udf
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign ovf     = push && full && !flush;
  assign udf     = pop && empty && !flush;
  assign count   = cnt_q;
  assign rdata   = empty ? '0 : mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      if (pop_ok)  rptr_d = ptr_inc(rptr_q);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

endmodule

// File: rtl/xfp_ctl.sv
module xfp_ctl #(
  parameter int TRIG_W      = 8,
  parameter int NB_IRQ      = 14,
  parameter int TX_TRIG_RST = 0,
  parameter int RX_TRIG_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              tx_flush_w,
  input  logic              rx_flush_w,
  input  logic [TRIG_W-1:0] tx_trig_w,
  input  logic [TRIG_W-1:0] rx_trig_w,
  input  logic              wr_ien,
  input  logic [NB_IRQ-1:0] ien_w,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [TRIG_W-1:0] rx_trig,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic [NB_IRQ-1:0] ien
);

  logic [TRIG_W-1:0] tx_trig_q, tx_trig_d, rx_trig_q, rx_trig_d;
  logic              tx_fl_q, tx_fl_d, rx_fl_q, rx_fl_d;
  logic [NB_IRQ-1:0] ien_q, ien_d;

  always_comb begin
    tx_trig_d = tx_trig_q;
    rx_trig_d = rx_trig_q;
    ien_d     = ien_q;
    // flush strobes last a single cycle unless rewritten
    tx_fl_d   = wr_ctl && tx_flush_w;
    rx_fl_d   = wr_ctl && rx_flush_w;
    if (wr_ctl) begin
      tx_trig_d = tx_trig_w;
      rx_trig_d = rx_trig_w;
    end
    if (wr_ien) ien_d = ien_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_trig_q <= TRIG_W'(TX_TRIG_RST);
      rx_trig_q <= TRIG_W'(RX_TRIG_RST);
      tx_fl_q   <= 1'b0;
      rx_fl_q   <= 1'b0;
      ien_q     <= '0;
    end else begin
      tx_trig_q <= tx_trig_d;
      rx_trig_q <= rx_trig_d;
      tx_fl_q   <= tx_fl_d;
      rx_fl_q   <= rx_fl_d;
      ien_q     <= ien_d;
    end
  end

  assign tx_trig  = tx_trig_q;
  assign rx_trig  = rx_trig_q;
  assign tx_flush = tx_fl_q;
  assign rx_flush = rx_fl_q;
  assign ien      = ien_q;

endmodule

// File: rtl/xfp_irq.sv
module xfp_irq #(
  parameter int NB_IRQ = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB_IRQ-1:0] set_vec,
  input  logic [NB_IRQ-1:0] clr_vec,
  input  logic [NB_IRQ-1:0] ien,
  output logic [NB_IRQ-1:0] sts,
  output logic              irq
);

  logic [NB_IRQ-1:0] sts_q, sts_d;

  // a bit being set this cycle wins over a clear request
  always_comb begin
    sts_d = (sts_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;
  assign irq = |(sts_q & ien);

endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
  import xfp_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int TRIG_W      = 8,
  parameter int TX_TRIG_RST = 0,
  parameter int RX_TRIG_RST = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_data_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  input  logic        xfer_done_i,
  input  logic        cs_release_i,
  output logic        irq_o
);

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int CMPW = (TRIG_W > CW) ? TRIG_W : CW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic wr_ctl, wr_ien, wr_sts, wr_txd, rd_rxd;
  assign wr_ctl = reg_wr && (reg_addr == A_CTL);
  assign wr_ien = reg_wr && (reg_addr == A_IEN);
  assign wr_sts = reg_wr && (reg_addr == A_STS);
  assign wr_txd = reg_wr && (reg_addr == A_TXD);
  assign rd_rxd = reg_rd && (reg_addr == A_RXD);

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[30:24], reg_wdata[14]};

  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic              tx_flush, rx_flush;
  logic [NB_IRQ-1:0] ien, sts, set_vec, clr_vec;

  xfp_ctl #(
    .TRIG_W(TRIG_W), .NB_IRQ(NB_IRQ),
    .TX_TRIG_RST(TX_TRIG_RST), .RX_TRIG_RST(RX_TRIG_RST)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_ctl    (wr_ctl),
    .tx_flush_w(reg_wdata[C_TX_FLUSH]),
    .rx_flush_w(reg_wdata[C_RX_FLUSH]),
    .tx_trig_w (reg_wdata[C_TX_TRIG +: TRIG_W]),
    .rx_trig_w (reg_wdata[C_RX_TRIG +: TRIG_W]),
    .wr_ien    (wr_ien),
    .ien_w     (reg_wdata[NB_IRQ-1:0]),
    .tx_trig   (tx_trig),
    .rx_trig   (rx_trig),
    .tx_flush  (tx_flush),
    .rx_flush  (rx_flush),
    .ien       (ien)
  );

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    rx_head;
  logic          tx_full, tx_empty, tx_ovf, tx_udf;
  logic          rx_full, rx_empty, rx_ovf, rx_udf;

  xfp_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk  (clk),
    .rst_n(rst_n_i),
    .flush(tx_flush),
    .push (wr_txd),
    .wdata(reg_wdata[7:0]),
    .pop  (tx_pop_i),
    .rdata(tx_data_o),
    .count(tx_cnt),
    .full (tx_full),
    .empty(tx_empty),
    .ovf  (tx_ovf),
    .udf  (tx_udf)
  );

  xfp_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk  (clk),
    .rst_n(rst_n_i),
    .flush(rx_flush),
    .push (rx_push_i),
    .wdata(rx_data_i),
    .pop  (rd_rxd),
    .rdata(rx_head),
    .count(rx_cnt),
    .full (rx_full),
    .empty(rx_empty),
    .ovf  (rx_ovf),
    .udf  (rx_udf)
  );

  logic tx_below, rx_above;
  assign tx_below = (CMPW'(tx_cnt) <= CMPW'(tx_trig));
  assign rx_above = (CMPW'(rx_cnt) >= CMPW'(rx_trig));

  always_comb begin
    set_vec            = '0;
    set_vec[B_RX_RDY]  = rx_above;
    set_vec[B_RX_EMP]  = rx_empty;
    set_vec[B_RX_FULL] = rx_full;
    set_vec[B_TX_REQ]  = tx_below;
    set_vec[B_TX_EMP]  = tx_empty;
    set_vec[B_TX_FULL] = tx_full;
    set_vec[B_RX_OVR]  = rx_ovf;
    set_vec[B_RX_UDR]  = rx_udf;
    set_vec[B_TX_OVR]  = tx_ovf;
    set_vec[B_TX_UDR]  = tx_udf;
    set_vec[B_DONE]    = xfer_done_i;
    set_vec[B_CSREL]   = cs_release_i;
    clr_vec = wr_sts ? reg_wdata[NB_IRQ-1:0] : '0;
  end

  xfp_irq #(.NB_IRQ(NB_IRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .ien    (ien),
    .sts    (sts),
    .irq    (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTL: begin
        reg_rdata[C_TX_FLUSH]          = tx_flush;
        reg_rdata[C_TX_TRIG +: TRIG_W] = tx_trig;
        reg_rdata[C_RX_FLUSH]          = rx_flush;
        reg_rdata[C_RX_TRIG +: TRIG_W] = rx_trig;
      end
      A_LVL: begin
        reg_rdata[16 +: CW] = tx_cnt;
        reg_rdata[0  +: CW] = rx_cnt;
      end
      A_IEN:   reg_rdata[NB_IRQ-1:0] = ien;
      A_STS:   reg_rdata[NB_IRQ-1:0] = sts;
      A_RXD:   reg_rdata[7:0]        = rx_head;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/xfer_fifo_pair_chk.sv
module xfer_fifo_pair_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic        clk,
  input logic        rst_n_i,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        tx_pop_i,
  input logic        xfer_done_i,
  input logic        tx_flush,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [13:0] sts,
  input logic        irq_o
);

  // R9
  tx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[31]) |=> ##1 (tx_cnt == '0));

  // R5
  tx_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    tx_cnt <= CW'(DEPTH));

  // R6
  tx_overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (tx_cnt == CW'(DEPTH) && reg_wr && reg_addr == 3'd4 && !tx_pop_i && !tx_flush)
    |=> (tx_cnt == CW'(DEPTH) && sts[10]));

  // R7
  rx_underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_rd && reg_addr == 3'd5 && rx_cnt == '0) |-> (reg_rdata == 32'h0));

  // R11
  done_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    xfer_done_i |=> sts[12]);

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[12] && !xfer_done_i) |=> !sts[12]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sts == '0) |-> !irq_o);

endmodule

bind xfer_fifo_pair xfer_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n_i    (rst_n_i),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .tx_pop_i   (tx_pop_i),
  .xfer_done_i(xfer_done_i),
  .tx_flush   (tx_flush),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .sts        (sts),
  .irq_o      (irq_o)
);

// File: tb/xfer_fifo_pair_tb.sv
`timescale 1ns/1ps
module xfer_fifo_pair_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_pop_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        rx_push_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        xfer_done_i = 1'b0, cs_release_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  xfer_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i),
    .xfer_done_i(xfer_done_i), .cs_release_i(cs_release_i),
    .irq_o(irq_o)
  );

  localparam logic [2:0] CTL = 3'd0, LVL = 3'd1, IEN = 3'd2, STS = 3'd3, TXD = 3'd4, RXD = 3'd5;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2, OP_RXP = 3'd3,
                         OP_TXP = 3'd4, OP_IRQ = 3'd5;
  localparam int NV = 28;
  // {op, addr, data, expected, requirement number}
  localparam logic [73:0] VEC [NV] = '{
    {OP_RD,  STS, 32'h0,        32'h32,       4'd1},  // R1 settled status
    {OP_WR,  STS, 32'h32,       32'h0,        4'd8},
    {OP_RD,  STS, 32'h0,        32'h32,       4'd8},  // R8 levels re-set
    {OP_WR,  CTL, 32'h00020002, 32'h0,        4'd4},
    {OP_WR,  TXD, 32'hA1,       32'h0,        4'd2},
    {OP_WR,  TXD, 32'hB2,       32'h0,        4'd2},
    {OP_WR,  TXD, 32'hC3,       32'h0,        4'd2},
    {OP_RD,  LVL, 32'h0,        32'h00030000, 4'd2},  // R2 count
    {OP_WR,  STS, 32'hFFFF,     32'h0,        4'd8},
    {OP_RD,  STS, 32'h0,        32'h2,        4'd4},  // R4 above trigger: no request
    {OP_TXP, 3'd0, 32'h0,       32'hA1,       4'd2},  // R2 oldest first
    {OP_IDLE,3'd0, 32'h0,       32'h0,        4'd0},
    {OP_RD,  STS, 32'h0,        32'h12,       4'd4},  // R4 request at trigger
    {OP_RXP, 3'd0, 32'h11,      32'h0,        4'd3},
    {OP_RXP, 3'd0, 32'h22,      32'h0,        4'd3},
    {OP_IDLE,3'd0, 32'h0,       32'h0,        4'd0},
    {OP_RD,  STS, 32'h0,        32'h13,       4'd4},  // R4 ready at trigger
    {OP_RD,  LVL, 32'h0,        32'h00020002, 4'd3},  // R3 counts
    {OP_RD,  RXD, 32'h0,        32'h11,       4'd3},
    {OP_RD,  RXD, 32'h0,        32'h22,       4'd3},
    {OP_RD,  RXD, 32'h0,        32'h0,        4'd7},  // R7 empty read
    {OP_RD,  STS, 32'h0,        32'h213,      4'd7},
    {OP_WR,  IEN, 32'h200,      32'h0,        4'd10},
    {OP_IRQ, 3'd0, 32'h0,       32'h1,        4'd10}, // R10
    {OP_WR,  STS, 32'h200,      32'h0,        4'd8},
    {OP_IRQ, 3'd0, 32'h0,       32'h0,        4'd10},
    {OP_RD,  STS, 32'h0,        32'h13,       4'd8},
    {OP_WR,  IEN, 32'h0,        32'h0,        4'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive_clear();
    reg_wr = 1'b0; reg_rd = 1'b0; tx_pop_i = 1'b0; rx_push_i = 1'b0;
    xfer_done_i = 1'b0; cs_release_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); drive_clear();
      @(posedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); drive_clear();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); drive_clear();
    reg_rd = 1'b1; reg_addr = a;
    #1 check(tag, reg_rdata, exp);
    @(posedge clk);
  endtask

  task automatic rd_bit(input int b, input logic exp, input string tag);
    @(negedge clk); drive_clear();
    reg_addr = STS;
    #1 check(tag, {31'h0, reg_rdata[b]}, {31'h0, exp});
    @(posedge clk);
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); drive_clear();
    rx_push_i = 1'b1; rx_data_i = d;
    @(posedge clk);
  endtask

  task automatic tx_pop(input logic [7:0] exp, input string tag);
    @(negedge clk); drive_clear();
    tx_pop_i = 1'b1;
    #1 check(tag, {24'h0, tx_data_o}, {24'h0, exp});
    @(posedge clk);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(negedge clk); drive_clear();
    #1 check(tag, {31'h0, irq_o}, {31'h0, exp});
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(3);

    // R1 reset values
    rd(CTL, 32'h00000001, "R1 control");
    rd(LVL, 32'h0, "R1 levels");
    rd(IEN, 32'h0, "R1 enable");
    irq_is(1'b0, "R1 irq");

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [2:0]  op, a;
      logic [31:0] d, e;
      string tag;
      op = VEC[v][73:71]; a = VEC[v][70:68]; d = VEC[v][67:36]; e = VEC[v][35:4];
      tag = $sformatf("R%0d vector %0d", VEC[v][3:0], v);
      case (op)
        OP_WR:   wr(a, d);
        OP_RD:   rd(a, e, tag);
        OP_RXP:  rx_push(d[7:0]);
        OP_TXP:  tx_pop(e[7:0], tag);
        OP_IRQ:  irq_is(e[0], tag);
        default: idle(1);
      endcase
    end

    // R9 outbound flush, self-clearing
    wr(CTL, 32'h80020002);
    rd(CTL, 32'h80020002, "R9 tx flush visible");
    rd(CTL, 32'h00020002, "R9 tx flush cleared");
    rd(LVL, 32'h0, "R9 tx emptied");
    // R9 inbound flush
    rx_push(8'h55);
    wr(CTL, 32'h00028002);
    rd(CTL, 32'h00028002, "R9 rx flush visible");
    rd(CTL, 32'h00020002, "R9 rx flush cleared");
    rd(LVL, 32'h0, "R9 rx emptied");

    // R5 R6 outbound full, overrun, drain, underrun
    wr(STS, 32'hFFFF);
    for (int i = 0; i < 64; i++) wr(TXD, {24'h0, 8'(i) ^ 8'h5A});
    rd(LVL, 32'h00400000, "R5 tx count at depth");
    idle(1);
    rd_bit(6, 1'b1, "R5 tx full");
    wr(TXD, 32'hEE);
    idle(1);
    rd(LVL, 32'h00400000, "R6 overrun byte dropped");
    rd_bit(10, 1'b1, "R6 tx overrun");
    for (int i = 0; i < 64; i++) tx_pop(8'(i) ^ 8'h5A, "R2 tx order");
    tx_pop(8'h00, "R6 tx empty data");
    idle(1);
    rd_bit(11, 1'b1, "R6 tx underrun");
    rd_bit(5, 1'b1, "R5 tx empty");

    // R5 R7 inbound full and overrun
    wr(STS, 32'hFFFF);
    for (int i = 0; i < 65; i++) rx_push(8'(i) ^ 8'hA5);
    idle(1);
    rd(LVL, 32'h00000040, "R7 rx overrun byte dropped");
    rd_bit(8, 1'b1, "R7 rx overrun");
    rd_bit(2, 1'b1, "R5 rx full");
    for (int i = 0; i < 64; i++) rd(RXD, {24'h0, 8'(i) ^ 8'hA5}, "R3 rx order");
    rd(LVL, 32'h0, "R3 rx drained");

    // R11 events, R10 masking, R8 partial clear
    wr(STS, 32'hFFFF);
    @(negedge clk); drive_clear(); xfer_done_i = 1'b1; @(posedge clk);
    idle(1);
    rd_bit(12, 1'b1, "R11 done event");
    @(negedge clk); drive_clear(); cs_release_i = 1'b1; @(posedge clk);
    idle(1);
    rd_bit(13, 1'b1, "R11 cs release event");
    wr(IEN, 32'h2000);
    irq_is(1'b1, "R10 enabled bit");
    wr(STS, 32'h1000);
    rd_bit(12, 1'b0, "R8 cleared bit");
    rd_bit(13, 1'b1, "R8 zero written keeps bit");
    irq_is(1'b1, "R10 still pending");
    wr(STS, 32'h2000);
    irq_is(1'b0, "R10 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule